// File: doc/BRIEF.md
# Randomized Matrix Product Checker

This block decides whether a result matrix C really is the product A x B of two small square matrices of 8-bit unsigned integers. The multiplier that produced C sits outside the block. The block does not redo that multiplication. Each round it draws a 0/1 vector r from an internal pseudo-random generator and compares A·(B·r) against C·r. It then repeats the comparison with the bitwise complement of r. Every step is a matrix-vector product, so a full check costs a few times N² multiply-accumulate cycles instead of N³.

The three matrices are written element by element through a small load port while the block is idle. A one-cycle start pulse then launches a check of ROUNDS rounds. All products run through one shared multiply-accumulate unit. The check stops at the first comparison that disagrees and raises `err`. If every comparison agrees, it stops after the last round with `err` low. In both cases `done` then stays high until the next start.

Top module: `rmc_checker`

## Requirements
- R1: After reset, `done` and `err` are both low.
- R2: A write with `ld_en` high stores `ld_data` into one element, selected by `ld_row` and `ld_col`. The target matrix is chosen by `ld_sel`: 0 selects A, 1 selects B, 2 selects C. A and B keep only the low 8 bits. Writes are ignored while a check is running, meaning from the cycle after an accepted start until `done` rises.
- R3: Products and sums never overflow. Elements of A and B go up to 255, and C elements go up to N·255². Under these conditions a correct C never raises `err`, even when every input element is 255.
- R4: The generator is a 16-bit maximal-length LFSR with taps at bits 15, 13, 12 and 10, shifting left and feeding the tap XOR into bit 0. It is reset to the nonzero SEED and advances once at the start of every round, including the first. The round vector r is the low N bits of the advanced value, with bit j applying to column j. The second pass of the round uses the complement of r.
- R5: When C equals A x B, `err` stays low and `done` rises exactly 2·ROUNDS·(3·N²+1) clock edges after the edge that accepted start.
- R6: Each pass takes 3·N²+1 cycles. A pass that finds A(Bv) different from Cv sets `err`, and `done` rises at the end of that pass with no later pass run. The latency is the number of passes run times (3·N²+1).
- R7: If C differs from A x B in exactly one element, the mismatch is always caught in the first round.
- R8: `done` and `err` hold their values until the next accepted start. A start pulse while a check is running is ignored.
- R9: An accepted start clears `err` and `done` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; accepted only when no check is running |
| ld_en | input | 1 | Element write enable |
| ld_sel | input | 2 | Target matrix: 0 = A, 1 = B, 2 = C |
| ld_row | input | IW | Row index of the element written |
| ld_col | input | IW | Column index of the element written |
| ld_data | input | CW | Element value (A and B use the low 8 bits) |
| done | output | 1 | Check finished; held until next start |
| err | output | 1 | Mismatch found; held until next start |

## Verification
The hardest outcome to reach is an error that escapes the first round and is caught only later. A single wrong element is always found at once, because either r or its complement has a 1 in that element's column. The bench therefore predicts the first round vector from its own model of the generator. It picks two columns whose bits in that vector are equal, and moves one unit from one to the other within a row of C. This leaves both first-round sums unchanged, and the predicted detection round and latency are then checked cycle for cycle.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BR,
    ST_ABR,
    ST_CR,
    ST_CMP,
    ST_DONE
  } rmc_state_e;

  localparam logic [1:0] SEL_A = 2'd0;
  localparam logic [1:0] SEL_B = 2'd1;
  localparam logic [1:0] SEL_C = 2'd2;

  // x^16 + x^14 + x^13 + x^11 + 1, shift toward the MSB
  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/rmc_mat_store.sv
module rmc_mat_store import rmc_pkg::*; #(
  parameter int N  = 3,
  parameter int EW = 8,
  parameter int CW = 18,
  parameter int IW = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      busy,
  input  logic                      ld_en,
  input  logic [1:0]                ld_sel,
  input  logic [IW-1:0]             ld_row,
  input  logic [IW-1:0]             ld_col,
  input  logic [CW-1:0]             ld_data,
  output logic [N*N-1:0][EW-1:0]    a_q,
  output logic [N*N-1:0][EW-1:0]    b_q,
  output logic [N*N-1:0][CW-1:0]    c_q
);
  localparam int CELLS = N * N;
  localparam int CIW   = (CELLS > 1) ? $clog2(CELLS) : 1;

  logic           in_range;
  logic           wr_ok;
  logic [CIW-1:0] cidx;

  assign in_range = ({1'b0, ld_row} < (IW+1)'(N)) && ({1'b0, ld_col} < (IW+1)'(N));
  assign wr_ok    = ld_en && !busy && in_range;
  assign cidx     = CIW'(int'(ld_row) * N + int'(ld_col));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else if (wr_ok) begin
      case (ld_sel)
        SEL_A:   a_q[cidx] <= ld_data[EW-1:0];
        SEL_B:   b_q[cidx] <= ld_data[EW-1:0];
        SEL_C:   c_q[cidx] <= ld_data;
        default: ;
      endcase
    end
  end

  // R2: matrices frozen while a check runs
  a_r2_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(a_q) && $stable(b_q) && $stable(c_q)));

endmodule

// File: rtl/rmc_lfsr.sv
module rmc_lfsr import rmc_pkg::*; #(
  parameter int          NB   = 3,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [NB-1:0] low_bits
);
  logic [15:0] lfsr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lfsr_q <= SEED;
    else if (step)  lfsr_q <= lfsr_next(lfsr_q);
  end

  assign low_bits = lfsr_q[NB-1:0];

  // R4: generator never falls into the all-zero lock state
  a_r4_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'h0000);

endmodule

// File: rtl/rmc_mv_engine.sv
module rmc_mv_engine #(
  parameter int N  = 3,
  parameter int CW = 18,
  parameter int BW = 10,
  parameter int AW = 20,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] m_elem,
  input  logic [BW-1:0] v_elem,
  output logic [IW-1:0] row,
  output logic [IW-1:0] col,
  output logic          row_end,
  output logic          pass_end,
  output logic [AW-1:0] dot
);
  localparam int PW = CW + BW;

  logic [IW-1:0] row_q, col_q;
  logic [AW-1:0] acc_q;
  logic [PW-1:0] prod_full;
  logic [AW:0]   sum_wide;

  function automatic logic [PW-1:0] mul_full(input logic [CW-1:0] m,
                                             input logic [BW-1:0] v);
    return PW'(m) * PW'(v);
  endfunction

  assign prod_full = mul_full(m_elem, v_elem);
  assign sum_wide  = {1'b0, acc_q} + {1'b0, prod_full[AW-1:0]};
  assign dot       = sum_wide[AW-1:0];
  assign row       = row_q;
  assign col       = col_q;
  assign row_end   = run && (col_q == IW'(N-1));
  assign pass_end  = row_end && (row_q == IW'(N-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
      acc_q <= '0;
    end else if (!run) begin
      row_q <= '0;
      col_q <= '0;
      acc_q <= '0;
    end else if (row_end) begin
      acc_q <= '0;
      col_q <= '0;
      row_q <= pass_end ? '0 : row_q + 1'b1;
    end else begin
      acc_q <= dot;
      col_q <= col_q + 1'b1;
    end
  end

  // R3: no product or running sum exceeds the accumulator
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (prod_full[PW-1:AW] == '0) && !sum_wide[AW]);

  a_r5_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, col_q} < (IW+1)'(N)) && ({1'b0, row_q} < (IW+1)'(N)));

endmodule

// File: rtl/rmc_checker.sv
module rmc_checker import rmc_pkg::*; #(
  parameter int          N      = 3,
  parameter int          EW     = 8,
  parameter int          ROUNDS = 4,
  parameter logic [15:0] SEED   = 16'hACE1,
  localparam int         LG     = $clog2(N + 1),
  localparam int         CW     = 2 * EW + LG,
  localparam int         BW     = EW + LG,
  localparam int         AW     = 2 * EW + 2 * LG,
  localparam int         IW     = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ld_en,
  input  logic [1:0]    ld_sel,
  input  logic [IW-1:0] ld_row,
  input  logic [IW-1:0] ld_col,
  input  logic [CW-1:0] ld_data,
  output logic          done,
  output logic          err
);
  localparam int CIW = (N * N > 1) ? $clog2(N * N) : 1;
  localparam int RW  = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

  rmc_state_e state_q;
  logic       pass_q;
  logic [RW-1:0] round_q;
  logic       err_q;

  logic [N*N-1:0][EW-1:0] a_q, b_q;
  logic [N*N-1:0][CW-1:0] c_q;
  logic [N-1:0]           r_raw, rv;
  logic [N-1:0][BW-1:0]   br_q;
  logic [N-1:0][AW-1:0]   abr_q, cr_q;

  logic          busy, start_go, run, row_end, pass_end, cmp_fail;
  logic          last_round, round_adv, lfsr_step;
  logic [IW-1:0] row, col;
  logic [CIW-1:0] cidx;
  logic [CW-1:0] m_elem;
  logic [BW-1:0] v_elem;
  logic [AW-1:0] dot;

  assign busy       = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign start_go   = start && !busy;
  assign run        = (state_q == ST_BR) || (state_q == ST_ABR) || (state_q == ST_CR);
  assign cmp_fail   = (abr_q != cr_q);
  assign last_round = (round_q == RW'(ROUNDS - 1));
  assign round_adv  = (state_q == ST_CMP) && !cmp_fail && pass_q && !last_round;
  assign lfsr_step  = start_go || round_adv;
  assign rv         = r_raw ^ {N{pass_q}};
  assign cidx       = CIW'(int'(row) * N + int'(col));

  rmc_mat_store #(.N(N), .EW(EW), .CW(CW), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_row(ld_row), .ld_col(ld_col), .ld_data(ld_data),
    .a_q(a_q), .b_q(b_q), .c_q(c_q)
  );

  rmc_lfsr #(.NB(N), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(lfsr_step), .low_bits(r_raw)
  );

  rmc_mv_engine #(.N(N), .CW(CW), .BW(BW), .AW(AW), .IW(IW)) u_mac (
    .clk(clk), .rst_n(rst_n), .run(run), .m_elem(m_elem), .v_elem(v_elem),
    .row(row), .col(col), .row_end(row_end), .pass_end(pass_end), .dot(dot)
  );

  // operand selection for the shared multiply-accumulate
  always_comb begin
    m_elem = '0;
    v_elem = '0;
    case (state_q)
      ST_BR:  begin m_elem = CW'(b_q[cidx]); v_elem = BW'(rv[col]); end
      ST_ABR: begin m_elem = CW'(a_q[cidx]); v_elem = br_q[col];    end
      ST_CR:  begin m_elem = c_q[cidx];      v_elem = BW'(rv[col]); end
      default: ;
    endcase
  end

  // result vectors
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_q  <= '0;
      abr_q <= '0;
      cr_q  <= '0;
    end else if (row_end) begin
      case (state_q)
        ST_BR:   br_q[row]  <= dot[BW-1:0];
        ST_ABR:  abr_q[row] <= dot;
        ST_CR:   cr_q[row]  <= dot;
        default: ;
      endcase
    end
  end

  // sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pass_q  <= 1'b0;
      round_q <= '0;
      err_q   <= 1'b0;
    end else if (start_go) begin
      state_q <= ST_BR;
      pass_q  <= 1'b0;
      round_q <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_BR:  if (pass_end) state_q <= ST_ABR;
        ST_ABR: if (pass_end) state_q <= ST_CR;
        ST_CR:  if (pass_end) state_q <= ST_CMP;
        ST_CMP: begin
          if (cmp_fail) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end else if (!pass_q) begin
            pass_q  <= 1'b1;
            state_q <= ST_BR;
          end else if (last_round) begin
            state_q <= ST_DONE;
          end else begin
            round_q <= round_q + 1'b1;
            pass_q  <= 1'b0;
            state_q <= ST_BR;
          end
        end
        default: ;
      endcase
    end
  end

  assign done = (state_q == ST_DONE);
  assign err  = err_q;

  // R6: the flag only rises out of a comparison step
  a_r6_err_from_compare: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(state_q == ST_CMP));

  // R5: completion only follows a comparison step
  a_r5_done_after_compare: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state_q == ST_CMP));

  // R8: flag is sticky until an accepted start
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !start_go) |=> err_q);

  // R8: completion is held until an accepted start
  a_r8_done_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R9: accepted start clears both flags
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> (!err_q && !done && state_q == ST_BR));

endmodule

// File: tb/rmc_checker_bench.sv
`timescale 1ns/1ps
module rmc_checker_bench;
  localparam int N      = 3;
  localparam int ROUNDS = 4;
  localparam int CW     = 18;
  localparam int PASS_CYC = 3 * N * N + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          ld_en = 1'b0;
  logic [1:0]    ld_sel = '0;
  logic [1:0]    ld_row = '0;
  logic [1:0]    ld_col = '0;
  logic [CW-1:0] ld_data = '0;
  logic          done, err;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int ma[N][N];
  int mb[N][N];
  int mc[N][N];
  logic [15:0] m_lfsr = 16'hACE1;

  rmc_checker #(.N(N), .EW(8), .ROUNDS(ROUNDS), .SEED(16'hACE1)) u_rmc_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_row(ld_row), .ld_col(ld_col), .ld_data(ld_data), .done(done), .err(err)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] step16(input logic [15:0] s);
    logic fb;
    fb = ^(s & 16'hB400);
    return {s[14:0], fb};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected outcome of one check from the current generator mirror
  function automatic void predict(output bit e, output int lat, output int steps);
    logic [15:0] s;
    int br[N];
    int ab;
    int cr;
    bit mism;
    s = m_lfsr;
    e = 0; lat = 0; steps = 0;
    for (int rd = 0; rd < ROUNDS; rd++) begin
      s = step16(s);
      steps++;
      for (int ps = 0; ps < 2; ps++) begin
        lat += PASS_CYC;
        mism = 0;
        for (int i = 0; i < N; i++) begin
          br[i] = 0;
          for (int j = 0; j < N; j++) br[i] += mb[i][j] * int'(s[j] ^ ps[0]);
        end
        for (int i = 0; i < N; i++) begin
          ab = 0; cr = 0;
          for (int j = 0; j < N; j++) begin
            ab += ma[i][j] * br[j];
            cr += mc[i][j] * int'(s[j] ^ ps[0]);
          end
          if (ab != cr) mism = 1;
        end
        if (mism) begin
          e = 1;
          return;
        end
      end
    end
  endfunction

  task automatic product_into_c();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        mc[i][j] = 0;
        for (int k = 0; k < N; k++) mc[i][j] += ma[i][k] * mb[k][j];
      end
  endtask

  task automatic fill_random(input int lo, input int hi);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = lo + int'($urandom % (hi - lo + 1));
        mb[i][j] = lo + int'($urandom % (hi - lo + 1));
      end
    product_into_c();
  endtask

  task automatic write_elem(input int sel, input int i, input int j, input int v);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = 2'(sel); ld_row = 2'(i); ld_col = 2'(j); ld_data = CW'(v);
  endtask

  task automatic load_all();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        write_elem(0, i, j, ma[i][j]);
        write_elem(1, i, j, mb[i][j]);
        write_elem(2, i, j, mc[i][j]);
      end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // mid: 0 none, 1 write C while running, 2 start while running
  task automatic run_case(input string req, input int mid);
    bit e;
    int lat, steps, cnt;
    predict(e, lat, steps);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(!done && !err, "R9", "flags cleared after start", {done, err}, 0);
    cnt = 0;
    while (!done && cnt < 5000) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (cnt == 10 && mid == 1) begin
        ld_en = 1'b1; ld_sel = 2'd2; ld_row = 2'd0; ld_col = 2'd0;
        ld_data = CW'(mc[0][0] + 77);
      end
      if (cnt == 10 && mid == 2) start = 1'b1;
      if (cnt == 11) begin ld_en = 1'b0; start = 1'b0; end
    end
    chk(err == e, req, "err at completion", err, e);
    chk(cnt == lat, req, "completion latency", cnt, lat);
    repeat (3) @(negedge clk);
    chk(done && err == e, "R8", "flags held after completion", {done, err}, {1'b1, e});
    for (int k = 0; k < steps; k++) m_lfsr = step16(m_lfsr);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int p, q;
    logic [15:0] s1;
    void'($urandom(32'd20061017));
    repeat (3) @(negedge clk);
    chk(!done && !err, "R1", "reset state", {done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: all-zero matrices, correct product
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin ma[i][j] = 0; mb[i][j] = 0; end
    product_into_c();
    load_all();
    run_case("R5", 0);

    // R5: random correct products
    for (int t = 0; t < 3; t++) begin
      fill_random(0, 255);
      load_all();
      run_case("R5", 0);
    end

    // R3: every element at full scale
    fill_random(255, 255);
    load_all();
    run_case("R3", 0);

    // R7: one corrupted element of C, caught in round 0
    for (int t = 0; t < 3; t++) begin
      int ci, cj;
      fill_random(0, 255);
      ci = int'($urandom % N);
      cj = int'($urandom % N);
      mc[ci][cj] = (mc[ci][cj] + 1 + int'($urandom % 1000)) % (1 << CW);
      load_all();
      run_case("R6", 0);
      chk(err == 1'b1 && done, "R7", "single error flagged", err, 1);
    end
    begin
      int ci;
      fill_random(1, 255);
      ci = int'($urandom % N);
      mc[ci][N-1] = mc[ci][N-1] + 5;
      load_all();
      run_case("R7", 0);
    end

    // R4: error hidden from the first round's vector and its complement
    fill_random(1, 255);
    s1 = step16(m_lfsr);
    p = 0; q = 1;
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++)
        if (s1[a] == s1[b]) begin p = a; q = b; end
    mc[1][p] = mc[1][p] + 1;
    mc[1][q] = mc[1][q] - 1;
    load_all();
    run_case("R4", 0);

    // R2: write during a running check has no effect
    fill_random(0, 255);
    load_all();
    run_case("R2", 1);
    run_case("R2", 0);

    // R8: start during a running check has no effect
    run_case("R8", 2);

    // R2: unused select code does not touch C
    write_elem(3, 0, 0, 12345);
    @(negedge clk);
    ld_en = 1'b0;
    run_case("R2", 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule